// File: doc/BRIEF.md
# Command-Gated Serial Register Port

This block is a four-wire serial slave that gives a host access to a small bank of registers. The wires are an active-low select (`cs_n`), serial data in (`sdi`), serial clock (`sclk`) and one output (`sdo_rdy`) that carries both read data and a result-ready flag. All three inputs are brought into the system clock through synchronizers, and the serial clock is handled as edges seen in that domain. Every access starts with an 8-bit command byte that picks a read or a write and a register address. The port then moves that register's bits MSB first: it samples input on rising `sclk` and changes output on falling `sclk`, so the host idles `sclk` high. The status register at address 0 is 8 bits wide and read-only. The result register at address 3 is 24 bits wide and is loaded only by the conversion side. The other six addresses are 24-bit read/write registers.

The conversion side is modelled by two strobes. `res_valid` loads `res_word` into the result register and lowers the ready flag. `pre_upd` raises the flag ahead of an update. A completed read of the result register also raises the flag. While select is low and no read data is being shifted, `sdo_rdy` shows the flag, with low meaning a fresh result is waiting. A continuous-read command lets the host pull result words one after another without sending a new command each time.

The controller has four states. ST_CMD collects the command byte. ST_WR shifts in write data. ST_RD shifts out read data. ST_CREAD repeats result-word reads. Transitions:
- ST_CMD goes to ST_WR, ST_RD or ST_CREAD on an accepted command byte.
- ST_WR and ST_RD return to ST_CMD after their last bit.
- ST_CREAD returns to ST_CMD after a word whose first input byte is the exit code.
- Any state goes to ST_CMD when select is released mid-word.
- Any state goes to ST_CMD after 32 consecutive ones on `sdi`.

Top module: `cmd_serial_port`

## Requirements
- R1: After hardware reset the port is in ST_CMD, the ready flag is high, every register reads zero and the status register reads 0x80.
- R2: A command byte is accepted only when bit 7 is 0 and bits 1:0 are 00. Bit 6 selects read (1) or write (0), bits 5:3 give the address, and bit 2 requests continuous read. A rejected byte leaves the port in ST_CMD, waiting for a fresh command byte.
- R3: A write command followed by 24 data bits, MSB first, updates addresses 1, 2 and 4 to 7 when the last bit arrives. The data bits of a write to address 0 or 3 are shifted in and thrown away.
- R4: A read command is followed by the register's bits, MSB first: 8 bits for address 0 and 24 bits for every other address. Each bit appears on `sdo_rdy` after a falling `sclk` edge and is valid at the next rising edge.
- R5: `res_valid` loads `res_word` into the result register and lowers the ready flag. While `cs_n` is low and no read data is being shifted, `sdo_rdy` shows the flag. Status bit 7 holds the flag and bits 6:0 read zero.
- R6: A completed read of the result register raises the ready flag. A read of the status register leaves the flag unchanged.
- R7: `pre_upd` raises the ready flag. When `res_valid` arrives in the same cycle, `res_valid` wins.
- R8: The result register keeps its word until the next `res_valid`, so the same word can be read any number of times.
- R9: Command 0x5C (read, address 3, continuous) enters ST_CREAD. Each 24-clock word in that state returns the result register with no command byte, and releasing select between words keeps the mode. A word whose first 8 input bits are 0x58 returns the port to ST_CMD once that word ends.
- R10: Releasing `cs_n` before a word ends aborts the transfer: no register is written and the port returns to ST_CMD.
- R11: Thirty-two consecutive ones sampled on `sdi` with select low put the port, the registers and the ready flag back into their reset state.
- R12: While `cs_n` is high, `sdo_rdy` is driven high and `sclk` edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data into the port |
| res_valid | input | 1 | Result strobe: loads `res_word` into the result register |
| res_word | input | 24 | New result word |
| pre_upd | input | 1 | Strobe issued ahead of a result update; raises the ready flag |
| sdo_rdy | output | 1 | Read data while shifting out, otherwise the ready flag (low means ready) |

## Verification
A wrong state register shows up within one byte. If the port misreads a command or leaves ST_CMD on a rejected byte, the next command is taken as data, and the following read returns a shifted or zero word. A stuck or misprioritised ready flag is visible on `sdo_rdy` a few system clocks after select falls, and it is also visible in status bit 7 on the next status read. Faults in the bit counter or the width table make reads return shifted words and leave writes either missing or truncated, so the first read-back after the bad access exposes them.

// File: rtl/srp_pkg.sv
package srp_pkg;

    localparam int CMD_BITS = 8;
    localparam int ADDR_W   = 3;
    localparam int NREGS    = 1 << ADDR_W;

    localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
    localparam logic [ADDR_W-1:0] A_DATA   = 3'd3;

    // read, result address, no continuous flag: leaves continuous read
    localparam logic [CMD_BITS-1:0] EXIT_CMD = 8'h58;

    typedef enum logic [1:0] {
        ST_CMD   = 2'd0,
        ST_WR    = 2'd1,
        ST_RD    = 2'd2,
        ST_CREAD = 2'd3
    } srp_state_e;

    typedef struct packed {
        logic              wen_n;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic              cread;
        logic [1:0]        pad;
    } cmd_t;

    function automatic logic is_writable(input logic [ADDR_W-1:0] a);
        return (a != A_STATUS) && (a != A_DATA);
    endfunction

endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    generate
        for (genvar g = 0; g < W; g++) begin : g_bit
            logic [STAGES:0] chain;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= {(STAGES+1){RST_VAL[g]}};
                end else begin
                    chain <= {chain[STAGES-1:0], async_in[g]};
                end
            end

            assign lvl[g]  = chain[STAGES-1];
            assign rise[g] = chain[STAGES-1] & ~chain[STAGES];
            assign fall[g] = ~chain[STAGES-1] & chain[STAGES];
        end
    endgenerate

endmodule

// File: rtl/srp_regs.sv
module srp_regs
    import srp_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_word,
    input  logic              pre_upd,
    input  logic              data_read_done,
    output logic              rdy_n
);

    logic [DATA_W-1:0] view [NREGS];
    logic              rdy_q;
    logic [STAT_W-1:0] status;

    assign status = {rdy_q, {(STAT_W-1){1'b0}}};

    generate
        for (genvar a = 0; a < NREGS; a++) begin : g_reg
            if (a == int'(A_STATUS)) begin : g_stat
                assign view[a] = {status, {(DATA_W-STAT_W){1'b0}}};
            end else if (a == int'(A_DATA)) begin : g_data
                logic [DATA_W-1:0] q;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)         q <= '0;
                    else if (soft_rst)  q <= '0;
                    else if (res_valid) q <= res_word;
                end
                assign view[a] = q;

                // R8
                data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (!res_valid && !soft_rst) |=> $stable(q));
            end else begin : g_rw
                logic [DATA_W-1:0] q;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)                                    q <= '0;
                    else if (soft_rst)                             q <= '0;
                    else if (wr_en && wr_addr == ADDR_W'(a))       q <= wr_data;
                end
                assign view[a] = q;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        rdy_q <= 1'b1;
        else if (soft_rst)                 rdy_q <= 1'b1;
        else if (res_valid)                rdy_q <= 1'b0;
        else if (pre_upd || data_read_done) rdy_q <= 1'b1;
    end

    assign rdy_n   = rdy_q;
    assign rd_word = view[rd_addr];

    // R5
    rdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !soft_rst) |=> !rdy_n);
    // R7
    pre_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_upd && !res_valid) |=> rdy_n);
    // R6
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_read_done && !res_valid) |=> rdy_n);
    // R3
    wr_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr != A_STATUS && wr_addr != A_DATA));

endmodule

// File: rtl/srp_fsm.sv
module srp_fsm
    import srp_pkg::*;
#(
    parameter int DATA_W   = 24,
    parameter int STAT_W   = 8,
    parameter int RST_ONES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              cs_rise,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sdi,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              rdy_n,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              data_read_done,
    output logic              soft_rst,
    output logic              sdo_rdy
);

    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam int ONES_W = $clog2(RST_ONES + 1);

    srp_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  bit_q;
    logic [CNT_W-1:0]  last_idx;
    logic [DATA_W-2:0] in_q;
    logic [DATA_W-1:0] out_q;
    logic              loaded_q;
    logic [ONES_W-1:0] ones_q;
    cmd_t              cmd;
    logic              rise_v, fall_v, cmd_done, cmd_ok, word_done;
    logic              out_phase, exit_hit, keep_cread;

    assign rise_v     = sclk_rise & ~cs_n;
    assign fall_v     = sclk_fall & ~cs_n;
    assign cmd        = cmd_t'({in_q[CMD_BITS-2:0], sdi});
    assign cmd_ok     = !cmd.wen_n && (cmd.pad == 2'b00);
    assign cmd_done   = rise_v && (state_q == ST_CMD) && (bit_q == CNT_W'(CMD_BITS-1));
    assign last_idx   = (addr_q == A_STATUS) ? CNT_W'(STAT_W-1) : CNT_W'(DATA_W-1);
    assign word_done  = rise_v && (state_q != ST_CMD) && (bit_q == last_idx);
    assign out_phase  = (state_q == ST_RD) || (state_q == ST_CREAD);
    assign exit_hit   = (in_q[DATA_W-2 -: CMD_BITS] == EXIT_CMD);
    assign keep_cread = (state_q == ST_CREAD) && (bit_q == '0);
    assign soft_rst   = rise_v && sdi && (ones_q == ONES_W'(RST_ONES-1));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CMD: begin
                if (cmd_done && cmd_ok) begin
                    if (!cmd.rd)                                 state_d = ST_WR;
                    else if (cmd.cread && cmd.addr == A_DATA)   state_d = ST_CREAD;
                    else                                         state_d = ST_RD;
                end
            end
            ST_WR, ST_RD: begin
                if (word_done) state_d = ST_CMD;
            end
            ST_CREAD: begin
                if (word_done && exit_hit) state_d = ST_CMD;
            end
            default: state_d = ST_CMD;
        endcase
        if (cs_rise && !keep_cread) state_d = ST_CMD;
        if (soft_rst)               state_d = ST_CMD;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CMD;
        else        state_q <= state_d;
    end

    // shifters and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            bit_q    <= '0;
            in_q     <= '0;
            out_q    <= '0;
            loaded_q <= 1'b0;
            ones_q   <= '0;
        end else if (soft_rst || (cs_rise && !keep_cread)) begin
            bit_q    <= '0;
            in_q     <= '0;
            loaded_q <= 1'b0;
            ones_q   <= '0;
            if (soft_rst) addr_q <= '0;
        end else begin
            if (cs_rise) ones_q <= '0;
            if (rise_v) begin
                ones_q <= sdi ? ones_q + 1'b1 : '0;
                if (cmd_done) begin
                    bit_q <= '0;
                    in_q  <= '0;
                    if (cmd_ok) addr_q <= cmd.addr;
                end else if (word_done) begin
                    bit_q    <= '0;
                    in_q     <= '0;
                    loaded_q <= 1'b0;
                end else begin
                    bit_q <= bit_q + 1'b1;
                    in_q  <= {in_q[DATA_W-3:0], sdi};
                end
            end
            if (fall_v && out_phase) begin
                if (!loaded_q) begin
                    out_q    <= rd_word;
                    loaded_q <= 1'b1;
                end else begin
                    out_q <= {out_q[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    // outputs
    always_comb begin
        rd_addr        = addr_q;
        wr_addr        = addr_q;
        wr_data        = {in_q, sdi};
        wr_en          = word_done && (state_q == ST_WR) && is_writable(addr_q) && !soft_rst;
        data_read_done = word_done && out_phase && (addr_q == A_DATA) && !soft_rst;
        if (cs_n)                        sdo_rdy = 1'b1;
        else if (out_phase && loaded_q)  sdo_rdy = out_q[DATA_W-1];
        else                             sdo_rdy = rdy_n;
    end

    // R11
    soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (state_q == ST_CMD));
    // R10
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !keep_cread) |=> (state_q == ST_CMD && bit_q == '0));
    // R2
    cmd_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && !cmd_ok) |=> (state_q == ST_CMD && bit_q == '0));
    // R4
    bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_CMD) |-> (bit_q <= last_idx));

endmodule

// File: rtl/cmd_serial_port.sv
module cmd_serial_port
    import srp_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int STAT_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int RST_ONES    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_word,
    input  logic              pre_upd,
    output logic              sdo_rdy
);

    localparam int I_SDI  = 0;
    localparam int I_SCLK = 1;
    localparam int I_CS   = 2;

    logic [2:0]        pins, lvl, rise, fall;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_word, wr_data;
    logic              wr_en, data_read_done, soft_rst, rdy_n;
    logic              unused_edges;

    assign pins         = {cs_n, sclk, sdi};
    assign unused_edges = ^{lvl[I_SCLK], rise[I_SDI], fall[I_SDI], fall[I_CS]};

    srp_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b110)
    ) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins),
        .lvl      (lvl),
        .rise     (rise),
        .fall     (fall)
    );

    srp_fsm #(
        .DATA_W   (DATA_W),
        .STAT_W   (STAT_W),
        .RST_ONES (RST_ONES)
    ) i_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .cs_n           (lvl[I_CS]),
        .cs_rise        (rise[I_CS]),
        .sclk_rise      (rise[I_SCLK]),
        .sclk_fall      (fall[I_SCLK]),
        .sdi            (lvl[I_SDI]),
        .rd_word        (rd_word),
        .rdy_n          (rdy_n),
        .rd_addr        (rd_addr),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .data_read_done (data_read_done),
        .soft_rst       (soft_rst),
        .sdo_rdy        (sdo_rdy)
    );

    srp_regs #(
        .DATA_W (DATA_W),
        .STAT_W (STAT_W)
    ) i_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .soft_rst       (soft_rst),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .rd_addr        (rd_addr),
        .rd_word        (rd_word),
        .res_valid      (res_valid),
        .res_word       (res_word),
        .pre_upd        (pre_upd),
        .data_read_done (data_read_done),
        .rdy_n          (rdy_n)
    );

endmodule

// File: tb/test_cmd_serial_port.sv
module test_cmd_serial_port;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int WDOG       = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic        sdi = 1'b0;
    logic        res_valid = 1'b0;
    logic [23:0] res_word = '0;
    logic        pre_upd = 1'b0;
    logic        sdo_rdy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [23:0] model [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_serial_port i_cmd_serial_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .res_valid (res_valid),
        .res_word  (res_word),
        .pre_upd   (pre_upd),
        .sdo_rdy   (sdo_rdy)
    );

    function automatic logic [7:0] cmd_byte(input logic rd, input logic [2:0] a, input logic cr);
        return {1'b0, rd, a, cr, 2'b00};
    endfunction

    function automatic int width_of(input logic [2:0] a);
        return (a == 3'd0) ? 8 : 24;
    endfunction

    function automatic logic [7:0] exp_status(input logic rdy_high);
        return {rdy_high, 7'b0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic cs_hi();
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic xfer(input int n, input logic [31:0] din, output logic [31:0] dout);
        dout = '0;
        for (int i = 0; i < n; i++) begin
            sclk = 1'b0;
            sdi  = din[n-1-i];
            repeat (HALF) @(negedge clk);
            dout = {dout[30:0], sdo_rdy};
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [23:0] v);
        logic [31:0] d;
        cs_lo();
        xfer(8, {24'b0, cmd_byte(1'b0, a, 1'b0)}, d);
        xfer(width_of(a), {8'b0, v}, d);
        cs_hi();
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [23:0] v);
        logic [31:0] d;
        cs_lo();
        xfer(8, {24'b0, cmd_byte(1'b1, a, 1'b0)}, d);
        xfer(width_of(a), 32'b0, d);
        cs_hi();
        v = d[23:0];
    endtask

    task automatic post_result(input logic [23:0] w);
        @(negedge clk);
        res_valid = 1'b1;
        res_word  = w;
        @(negedge clk);
        res_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_pre();
        @(negedge clk);
        pre_upd = 1'b1;
        @(negedge clk);
        pre_upd = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [23:0] v;
        logic [31:0] d;
        logic [23:0] w;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 8; k++) model[k] = '0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 / R12: idle output high, ready flag high after reset
        check("R12 idle output", {31'b0, sdo_rdy}, 32'd1);
        cs_lo();
        check("R1 ready flag after reset", {31'b0, sdo_rdy}, 32'd1);
        cs_hi();
        rd_reg(3'd0, v);
        check("R1 status after reset", {24'b0, v[7:0]}, {24'b0, exp_status(1'b1)});
        rd_reg(3'd6, v);
        check("R1 register zero after reset", {8'b0, v}, 32'd0);

        // R3 / R4: directed write and read-back
        wr_reg(3'd1, 24'hA5C3F0);
        model[1] = 24'hA5C3F0;
        rd_reg(3'd1, v);
        check("R3 write then read reg1", {8'b0, v}, {8'b0, model[1]});
        wr_reg(3'd7, 24'h800001);
        model[7] = 24'h800001;
        rd_reg(3'd7, v);
        check("R4 MSB-first edge bits reg7", {8'b0, v}, {8'b0, model[7]});

        // R3: writes to read-only addresses are dropped
        wr_reg(3'd3, 24'h123456);
        rd_reg(3'd3, v);
        check("R3 write to result ignored", {8'b0, v}, 32'd0);
        wr_reg(3'd0, 24'h0000FF);
        rd_reg(3'd0, v);
        check("R3 write to status ignored", {24'b0, v[7:0]}, {24'b0, exp_status(1'b1)});
        rd_reg(3'd1, v);
        check("R3 status write length kept framing", {8'b0, v}, {8'b0, model[1]});

        // R3 / R4 / R8: random traffic against the model
        for (int it = 0; it < 24; it++) begin
            logic [2:0] a;
            logic [2:0] b;
            int sel;
            sel = int'($urandom % 6);
            a = (sel < 2) ? 3'(sel + 1) : 3'(sel + 2);
            w = 24'($urandom);
            wr_reg(a, w);
            model[a] = w;
            sel = int'($urandom % 6);
            b = (sel < 2) ? 3'(sel + 1) : 3'(sel + 2);
            rd_reg(b, v);
            check("R3 random read-back", {8'b0, v}, {8'b0, model[b]});
            if ($urandom % 3 == 0) begin
                w = 24'($urandom);
                post_result(w);
                rd_reg(3'd3, v);
                check("R8 random result read", {8'b0, v}, {8'b0, w});
            end
        end

        // R5 / R6 / R8: ready handshake on the result register
        w = 24'h5A0F3C;
        post_result(w);
        cs_lo();
        check("R5 ready low on output", {31'b0, sdo_rdy}, 32'd0);
        cs_hi();
        rd_reg(3'd0, v);
        check("R5 status shows ready", {24'b0, v[7:0]}, {24'b0, exp_status(1'b0)});
        cs_lo();
        check("R6 status read leaves flag low", {31'b0, sdo_rdy}, 32'd0);
        cs_hi();
        rd_reg(3'd3, v);
        check("R5 result word", {8'b0, v}, {8'b0, w});
        cs_lo();
        check("R6 flag high after result read", {31'b0, sdo_rdy}, 32'd1);
        cs_hi();
        rd_reg(3'd3, v);
        check("R8 repeated read same word", {8'b0, v}, {8'b0, w});

        // R7: pre-update strobe raises the flag
        post_result(24'h00FFEE);
        cs_lo();
        check("R7 flag low before strobe", {31'b0, sdo_rdy}, 32'd0);
        pulse_pre();
        check("R7 flag high after strobe", {31'b0, sdo_rdy}, 32'd1);
        cs_hi();

        // R12: output high while deselected even with a result waiting
        post_result(24'h111111);
        check("R12 deselected output high", {31'b0, sdo_rdy}, 32'd1);
        rd_reg(3'd3, v);

        // R2: malformed command bytes are dropped
        cs_lo();
        xfer(8, 32'hC8, d);
        xfer(8, 32'h49, d);
        xfer(8, {24'b0, cmd_byte(1'b1, 3'd1, 1'b0)}, d);
        xfer(24, 32'b0, d);
        cs_hi();
        check("R2 rejected bytes then valid read", {8'b0, d[23:0]}, {8'b0, model[1]});

        // R10: abort mid-write
        cs_lo();
        xfer(8, {24'b0, cmd_byte(1'b0, 3'd2, 1'b0)}, d);
        xfer(10, 32'h2AA, d);
        cs_hi();
        rd_reg(3'd2, v);
        check("R10 aborted write dropped", {8'b0, v}, {8'b0, model[2]});
        cs_lo();
        xfer(8, {24'b0, cmd_byte(1'b1, 3'd4, 1'b0)}, d);
        xfer(5, 32'b0, d);
        cs_hi();
        rd_reg(3'd4, v);
        check("R10 port back to command after abort", {8'b0, v}, {8'b0, model[4]});

        // R9: continuous read
        cs_lo();
        xfer(8, 32'h5C, d);
        for (int k = 0; k < 3; k++) begin
            w = 24'($urandom);
            post_result(w);
            check("R9 flag low in continuous mode", {31'b0, sdo_rdy}, 32'd0);
            xfer(24, 32'b0, d);
            check("R9 continuous word", {8'b0, d[23:0]}, {8'b0, w});
            check("R9 flag high after word", {31'b0, sdo_rdy}, 32'd1);
        end
        cs_hi();
        w = 24'hC0FFEE;
        post_result(w);
        cs_lo();
        xfer(24, 32'b0, d);
        check("R9 mode kept across deselect", {8'b0, d[23:0]}, {8'b0, w});
        w = 24'h0BEEF0;
        post_result(w);
        xfer(24, {8'b0, 8'h58, 16'h0}, d);
        check("R9 exit word data", {8'b0, d[23:0]}, {8'b0, w});
        xfer(8, {24'b0, cmd_byte(1'b1, 3'd5, 1'b0)}, d);
        xfer(24, 32'b0, d);
        cs_hi();
        check("R9 commands accepted after exit", {8'b0, d[23:0]}, {8'b0, model[5]});

        // R11: 32 ones reset the port
        wr_reg(3'd5, 24'h13579B);
        post_result(24'h777777);
        cs_lo();
        xfer(32, 32'hFFFFFFFF, d);
        cs_hi();
        for (int k = 0; k < 8; k++) model[k] = '0;
        rd_reg(3'd5, v);
        check("R11 register cleared", {8'b0, v}, 32'd0);
        rd_reg(3'd0, v);
        check("R11 status after port reset", {24'b0, v[7:0]}, {24'b0, exp_status(1'b1)});
        rd_reg(3'd3, v);
        check("R11 result cleared", {8'b0, v}, 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule